// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block puts a synchronous cycle controller around a small on-chip word array that is split into byte lanes. On each rising clock edge it takes in the address, three chip-select inputs, two burst-start strobes (one for a processor-side master, one for a controller-side master), a step strobe, the write controls and the write data. It then classifies the cycle as a deselect, the start of a burst, a burst step, or a burst hold. The classified cycle is held in a stage register and carried out on the next edge. A write is masked per lane. A read loads a registered output word.

A burst covers an aligned group of 2^BURST_W words. The burst order can be linear (wrapping increment) or interleaved (XOR of the start offset with the step count), and it is chosen when the burst starts. The output-drive flag stands in for a tri-state pad enable: it is high only in the cycle in which read data is valid and the output-enable input was sampled active. A sleep input freezes all array access. The freeze lasts while sleep is high and for a fixed number of cycles after it falls.

Top module: `pbsram_ctl`

## Requirements
- R1: The part is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A cycle that starts a burst while the part is not selected is a deselect: no array access, the burst ends, and `drive_o` is 0 in the cycle where read data would have appeared.
- R2: When `en_a_n`=1, a low `pstrb_n` is ignored, and the cycle is treated as a step or hold of the running burst. A low `cstrb_n` in that case is a deselect.
- R3: A write is requested when `all_wr_n`=0 (all lanes are written), or when `byte_wr_n`=0 and at least one bit of `lane_sel_n` is 0. Bit g of `lane_sel_n` gates data bits [g*9+8 : g*9], so lane 0 is bits 8:0 and lane 3 is bits 35:27. When `byte_wr_n`=0 and every lane bit is 1, the cycle is a read.
- R4: A burst started by `pstrb_n`=0 while selected is always a read on that edge, whatever the write controls are.
- R5: A burst started by `cstrb_n`=0 (with `pstrb_n` ineffective) while selected is a write if R3 requests one, and a read otherwise. The start address is `addr_i`.
- R6: With no effective start strobe, a running burst and `step_n`=0, the burst moves to its next word. The upper address bits stay fixed. With `interleave_i`=0 at the start, the low 2 bits are the start offset plus the step count, mod 4. With `interleave_i`=1, they are the start offset XOR the step count.
- R7: With no effective start strobe, a running burst and `step_n`=1, the current address is used again, for reads and for writes alike.
- R8: Inputs sampled at edge k produce their read data on `rdata_o` after edge k+1. `drive_o` is 1 after edge k+1 only if the cycle was a read and `out_en_n` sampled at edge k+1 was 0.
- R9: `drive_o` is 0 in the cycle that follows a write access, whatever `out_en_n` is.
- R10: A read of an address issued in the cycle right after a write to that address returns the newly written data.
- R11: While `sleep_i`=1, and for 4 cycles after it is sampled low, no access happens, `drive_o` is 0 one cycle later, and the burst position is kept.
- R12: After reset, `drive_o` is 0 and no burst is running, so step and hold cycles cause no access until a burst is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Burst start address |
| en_a_n | input | 1 | Select input, active low; also gates `pstrb_n` |
| en_b | input | 1 | Select input, active high |
| en_c_n | input | 1 | Select input, active low |
| pstrb_n | input | 1 | Processor-side burst start, active low |
| cstrb_n | input | 1 | Controller-side burst start, active low |
| step_n | input | 1 | Burst step request, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| interleave_i | input | 1 | Burst order chosen at burst start: 1 interleaved, 0 linear |
| rdata_o | output | LANES*LANE_W | Registered read data |
| drive_o | output | 1 | Output-drive flag |

## Verification
Each cycle decision is due two edges after its inputs are sampled: the stage register takes it at edge k, and the array access, read word and drive flag land at edge k+1. The output enable counts only as sampled on that second edge. The bench model follows the same two steps. At each rising edge it first retires the cycle it queued one edge earlier, then classifies the inputs sampled on the current edge. It compares `drive_o`, and `rdata_o` whenever a drive is expected, at the following falling edge. This keeps every comparison clear of the edge itself. Sleep release, pass-through after a write, and the burst orders are checked in directed runs against the same model.

// File: rtl/pbsram_pkg.sv
`timescale 1ns/1ps
package pbsram_pkg;
  // Access queued for the array stage
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Classified cycle kind for the burst sequencer
  typedef enum logic [1:0] {
    CY_DESEL = 2'd0,
    CY_BEGIN = 2'd1,
    CY_CONT  = 2'd2,
    CY_HOLD  = 2'd3
  } cyc_e;
endpackage

// File: rtl/pbsram_cycle_decode.sv
`timescale 1ns/1ps
module pbsram_cycle_decode import pbsram_pkg::*; #(
  parameter int LANES = 4
) (
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             blocked,
  input  logic             burst_live,
  output cyc_e             cyc,
  output op_e              op,
  output logic [LANES-1:0] wmask
);
  logic             selected;
  logic             p_start;
  logic             any_start;
  logic [LANES-1:0] req_mask;

  always_comb begin
    selected  = !en_a_n && en_b && !en_c_n;
    p_start   = !pstrb_n && !en_a_n;          // processor start gated by first select
    any_start = p_start || !cstrb_n;
    if (!all_wr_n)       req_mask = '1;
    else if (!byte_wr_n) req_mask = ~lane_sel_n;
    else                 req_mask = '0;

    cyc   = CY_HOLD;
    op    = OP_IDLE;
    wmask = '0;
    if (blocked) begin
      cyc = CY_HOLD;                           // frozen: no access, position kept
    end else if (any_start) begin
      if (selected) begin
        cyc = CY_BEGIN;
        if (p_start || (req_mask == '0)) begin
          op = OP_READ;                        // processor start forces a read
        end else begin
          op    = OP_WRITE;
          wmask = req_mask;
        end
      end else begin
        cyc = CY_DESEL;
      end
    end else if (burst_live) begin
      cyc = step_n ? CY_HOLD : CY_CONT;
      if (req_mask != '0) begin
        op    = OP_WRITE;
        wmask = req_mask;
      end else begin
        op = OP_READ;
      end
    end
  end
endmodule

// File: rtl/pbsram_burst_seq.sv
`timescale 1ns/1ps
module pbsram_burst_seq import pbsram_pkg::*; #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_e              cyc,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              live_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_use;
  logic               ilv_q;
  logic               live_q;
  logic [BURST_W-1:0] low_bits;

  always_comb begin
    cnt_use = (cyc == CY_CONT) ? cnt_q + 1'b1 : cnt_q;
    if (ilv_q) low_bits = base_q[BURST_W-1:0] ^ cnt_use;
    else       low_bits = base_q[BURST_W-1:0] + cnt_use;
    if (cyc == CY_BEGIN) acc_addr = load_addr;
    else                 acc_addr = {base_q[ADDR_W-1 -: HI_W], low_bits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      case (cyc)
        CY_BEGIN: begin
          base_q <= load_addr;
          cnt_q  <= '0;
          ilv_q  <= interleave_i;
          live_q <= 1'b1;
        end
        CY_CONT:  cnt_q  <= cnt_q + 1'b1;
        CY_DESEL: live_q <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign live_o = live_q;

  // R6: a step moves the burst count on by exactly one
  assert_step_advances_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc == CY_CONT) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));

  // R7 / R11: a hold keeps base and count
  assert_hold_keeps_pos_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc == CY_HOLD) |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/pbsram_lane_bank.sv
`timescale 1ns/1ps
module pbsram_lane_bank #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/pbsram_ctl.sv
`timescale 1ns/1ps
module pbsram_ctl import pbsram_pkg::*; #(
  parameter int ADDR_W   = 6,
  parameter int LANE_W   = 9,
  parameter int LANES    = 4,
  parameter int BURST_W  = 2,
  parameter int WAKE_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    en_a_n,
  input  logic                    en_b,
  input  logic                    en_c_n,
  input  logic                    pstrb_n,
  input  logic                    cstrb_n,
  input  logic                    step_n,
  input  logic                    all_wr_n,
  input  logic                    byte_wr_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    out_en_n,
  input  logic                    sleep_i,
  input  logic                    interleave_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int CNT_W  = $clog2(WAKE_CYC + 1);

  logic [CNT_W-1:0]  slp_q;
  logic              blocked;
  cyc_e              dec_cyc;
  op_e               dec_op;
  logic [LANES-1:0]  dec_mask;
  logic              live;
  logic [ADDR_W-1:0] acc_addr;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  wmask_q;
  logic              rv_q;
  logic              oe_q;

  // Sleep window: active while requested and WAKE_CYC cycles after release
  always_ff @(posedge clk) begin
    if (rst)                slp_q <= '0;
    else if (sleep_i)       slp_q <= CNT_W'(WAKE_CYC);
    else if (slp_q != '0)   slp_q <= slp_q - 1'b1;
  end
  assign blocked = sleep_i || (slp_q != '0);

  pbsram_cycle_decode #(.LANES(LANES)) u_dec (
    .en_a_n     (en_a_n),
    .en_b       (en_b),
    .en_c_n     (en_c_n),
    .pstrb_n    (pstrb_n),
    .cstrb_n    (cstrb_n),
    .step_n     (step_n),
    .all_wr_n   (all_wr_n),
    .byte_wr_n  (byte_wr_n),
    .lane_sel_n (lane_sel_n),
    .blocked    (blocked),
    .burst_live (live),
    .cyc        (dec_cyc),
    .op         (dec_op),
    .wmask      (dec_mask)
  );

  pbsram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cyc          (dec_cyc),
    .load_addr    (addr_i),
    .interleave_i (interleave_i),
    .acc_addr     (acc_addr),
    .live_o       (live)
  );

  // Stage register: classified cycle waits one edge before the array
  always_ff @(posedge clk) begin
    if (rst) op_q <= OP_IDLE;
    else     op_q <= dec_op;
  end

  always_ff @(posedge clk) begin
    addr_q  <= acc_addr;
    wdata_q <= wdata_i;
    wmask_q <= dec_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      rv_q <= (op_q == OP_READ);
      oe_q <= !out_en_n;
    end
  end

  assign drive_o = rv_q && oe_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbsram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .wr_en ((op_q == OP_WRITE) && wmask_q[g]),
      .rd_en (op_q == OP_READ),
      .addr  (addr_q),
      .wdata (wdata_q[g*LANE_W +: LANE_W]),
      .rdata (rdata_o[g*LANE_W +: LANE_W])
    );
  end

  // R1: a controller start with the third select inactive queues nothing
  assert_desel_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!cstrb_n && en_c_n && !sleep_i) |=> (op_q == OP_IDLE));

  // R4: a selected processor start always queues a read
  assert_pstart_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!pstrb_n && !en_a_n && en_b && !en_c_n && !sleep_i && (slp_q == '0))
      |=> (op_q == OP_READ));

  // R8: a queued read with output enabled drives on the next edge
  assert_read_drives_R8: assert property (@(posedge clk) disable iff (rst)
    ((op_q == OP_READ) && !out_en_n) |=> drive_o);

  // R9: a write access never drives the outputs
  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_WRITE) |=> !drive_o);

  // R11: a sleep request suppresses the access
  assert_sleep_idle_R11: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> (op_q == OP_IDLE));
endmodule

// File: tb/tb_pbsram_ctl.sv
`timescale 1ns/1ps
module tb_pbsram_ctl;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_i;
  logic          en_a_n, en_b, en_c_n;
  logic          pstrb_n, cstrb_n, step_n;
  logic          all_wr_n, byte_wr_n;
  logic [LN-1:0] lane_sel_n;
  logic [DW-1:0] wdata_i;
  logic          out_en_n, sleep_i, interleave_i;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  always #10 clk = ~clk;   // 50 MHz

  pbsram_ctl dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .en_a_n(en_a_n), .en_b(en_b),
    .en_c_n(en_c_n), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
    .wdata_i(wdata_i), .out_en_n(out_en_n), .sleep_i(sleep_i),
    .interleave_i(interleave_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  string tag = "R12";

  // Reference model state
  logic [DW-1:0] mem_m [int];
  logic [1:0]    m_op;        // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_addr, m_base;
  logic [DW-1:0] m_wdata;
  logic [LN-1:0] m_mask;
  logic [1:0]    m_cnt;
  logic          m_ilv, m_live;
  int            m_slp;
  logic          exp_drive, exp_known;
  logic [DW-1:0] exp_data;

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] b, logic [1:0] c, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [LN-1:0] m);
    logic [DW-1:0] r;
    r = old;
    for (int g = 0; g < LN; g++) if (m[g]) r[g*LW +: LW] = nw[g*LW +: LW];
    return r;
  endfunction

  task automatic model_reset();
    m_op = 0; m_live = 0; m_cnt = 0; m_slp = 0; m_base = '0; m_ilv = 0;
    exp_drive = 0; exp_known = 0;
  endtask

  task automatic model_edge();
    logic blk, sel, pst, st;
    logic [LN-1:0] wm;
    logic [DW-1:0] old;
    // retire the queued access
    exp_drive = (m_op == 2'd1) && !out_en_n;
    exp_known = 0;
    if (m_op == 2'd1 && mem_m.exists(int'(m_addr))) begin
      exp_data = mem_m[int'(m_addr)]; exp_known = 1;
    end
    if (m_op == 2'd2) begin
      old = mem_m.exists(int'(m_addr)) ? mem_m[int'(m_addr)] : '0;
      mem_m[int'(m_addr)] = merge(old, m_wdata, m_mask);
    end
    // classify the newly sampled cycle
    blk   = sleep_i || (m_slp != 0);
    m_slp = sleep_i ? 4 : ((m_slp != 0) ? m_slp - 1 : 0);
    sel = !en_a_n && en_b && !en_c_n;
    pst = !pstrb_n && !en_a_n;
    st  = pst || !cstrb_n;
    wm  = !all_wr_n ? '1 : (!byte_wr_n ? ~lane_sel_n : '0);
    m_op = 0;
    if (!blk) begin
      if (st) begin
        if (sel) begin
          m_base = addr_i; m_cnt = 0; m_ilv = interleave_i; m_live = 1; m_addr = addr_i;
          if (pst || wm == 0) m_op = 1;
          else begin m_op = 2; m_mask = wm; m_wdata = wdata_i; end
        end else m_live = 0;
      end else if (m_live) begin
        if (!step_n) m_cnt = m_cnt + 2'd1;
        m_addr = burst_addr(m_base, m_cnt, m_ilv);
        if (wm != 0) begin m_op = 2; m_mask = wm; m_wdata = wdata_i; end
        else m_op = 1;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
    n_chk++;
    if (drive_o !== exp_drive) begin
      n_bad++;
      $display("FAIL %s drive: actual %b expected %b at %0t", tag, drive_o, exp_drive, $time);
    end
    if (exp_drive && exp_known) begin
      n_chk++;
      if (rdata_o !== exp_data) begin
        n_bad++;
        $display("FAIL %s data: actual %h expected %h at %0t", tag, rdata_o, exp_data, $time);
      end
    end
  endtask

  task automatic quiet();
    en_a_n = 0; en_b = 1; en_c_n = 0; pstrb_n = 1; cstrb_n = 1; step_n = 1;
    all_wr_n = 1; byte_wr_n = 1; lane_sel_n = '1; out_en_n = 0; sleep_i = 0;
    interleave_i = 0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic c_start(logic [AW-1:0] a, logic wr, logic [DW-1:0] d);
    quiet(); cstrb_n = 0; addr_i = a; all_wr_n = !wr; wdata_i = d; tick();
  endtask

  task automatic step(logic adv, logic wr, logic [DW-1:0] d);
    quiet(); step_n = !adv; all_wr_n = !wr; wdata_i = d; tick();
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    rst = 1;
    tag = "R12"; repeat (3) tick();
    rst = 0;
    tick();
    // R12: steps with no burst running cause no access
    tag = "R12"; quiet(); step_n = 0; repeat (3) tick();
    quiet(); step_n = 1; tick();

    // prefill every word (R5 controller-start writes)
    tag = "R5";
    for (int a = 0; a < (1 << AW); a++) c_start(a[AW-1:0], 1'b1, rnd_word());
    step(1'b0, 1'b0, '0);
    c_start(6'd3, 1'b0, '0); step(1'b1, 1'b0, '0); tick();

    // R6 linear order from offset 1
    tag = "R6"; quiet(); cstrb_n = 0; addr_i = 6'd13; tick();
    repeat (4) step(1'b1, 1'b0, '0);
    // R6 interleaved order from offset 1
    quiet(); cstrb_n = 0; addr_i = 6'd13; interleave_i = 1; tick();
    repeat (4) step(1'b1, 1'b0, '0);
    quiet(); tick(); tick();

    // R7 suspended write and read reuse the address
    tag = "R7"; c_start(6'd40, 1'b1, rnd_word());
    step(1'b0, 1'b1, rnd_word());
    step(1'b0, 1'b0, '0); step(1'b0, 1'b0, '0);

    // R4 processor start ignores write controls, then R10 pass-through
    tag = "R4"; quiet(); pstrb_n = 0; addr_i = 6'd20; all_wr_n = 0; wdata_i = rnd_word(); tick();
    tag = "R10"; step(1'b0, 1'b1, 36'h1_2345_6789);
    c_start(6'd20, 1'b0, '0); quiet(); tick(); tick();

    // R3 lane-masked writes
    tag = "R3";
    for (int g = 0; g < LN; g++) begin
      quiet(); cstrb_n = 0; addr_i = 6'd50; byte_wr_n = 0; lane_sel_n = ~(4'b1 << g);
      wdata_i = rnd_word(); tick();
    end
    quiet(); cstrb_n = 0; addr_i = 6'd50; byte_wr_n = 0; lane_sel_n = '1; tick();
    quiet(); tick(); tick();

    // R1 deselect on start without selection
    tag = "R1"; c_start(6'd8, 1'b0, '0);
    quiet(); cstrb_n = 0; en_b = 0; addr_i = 6'd9; tick();
    step(1'b1, 1'b0, '0); tick();

    // R2 processor start ignored with first select high; controller start deselects
    tag = "R2"; c_start(6'd8, 1'b0, '0);
    quiet(); en_a_n = 1; pstrb_n = 0; step_n = 0; addr_i = 6'd33; tick();
    quiet(); en_a_n = 1; cstrb_n = 0; tick();
    step(1'b1, 1'b0, '0); tick();

    // R8 output enable sampled one edge after the read
    tag = "R8"; c_start(6'd2, 1'b0, '0);
    quiet(); out_en_n = 1; tick(); tick();

    // R11 sleep freezes writes and reads
    tag = "R11"; c_start(6'd30, 1'b0, '0); tick();
    for (int i = 0; i < 7; i++) begin
      quiet(); sleep_i = (i < 3); cstrb_n = 0; addr_i = 6'd30; all_wr_n = 0;
      wdata_i = rnd_word(); tick();
    end
    c_start(6'd30, 1'b0, '0); quiet(); tick(); tick();

    // constrained random mix
    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      addr_i      = AW'($urandom);
      en_a_n      = ($urandom % 8) == 0;
      en_b        = ($urandom % 8) != 0;
      en_c_n      = ($urandom % 8) == 0;
      pstrb_n     = ($urandom % 4) != 0;
      cstrb_n     = ($urandom % 4) != 0;
      step_n      = $urandom % 2;
      all_wr_n    = ($urandom % 4) != 0;
      byte_wr_n   = $urandom % 2;
      lane_sel_n  = LN'($urandom);
      wdata_i     = rnd_word();
      out_en_n    = ($urandom % 5) == 0;
      sleep_i     = ($urandom % 64) == 0;
      interleave_i = $urandom % 2;
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule